// File: doc/BRIEF.md
# Sector Program Sequencer

This block sits on the system side of a byte-wide, 5-volt-only flash memory that is reprogrammed one 256-byte sector at a time. A start request carries a sector number and a flag that selects whether the three-write unlock prefix, which the memory needs while its write protection is on, goes out first. The sequencer then fetches each of the sector's 256 bytes from a local buffer through a one-cycle read-request port. It issues every byte to the memory as a timed write-enable pulse, in ascending byte order. The memory only keeps its load window open while byte loads follow each other closely, so every byte of the sector is sent, and the gap between loads is kept short and fixed.

After the last load the memory programs the whole sector on its own. The sequencer tracks this by repeatedly reading back the last loaded byte. Until programming has finished, bit 7 of that read returns the complement of the written value. The operation is complete when bit 7 matches the written value. If that does not happen within a programmable number of cycles, the sequencer reports a timeout error. Every duration is a parameter counted in clock cycles. Bus outputs come from flops, so the strobes cannot glitch.

Top module: `sector_prog_seq`

## Requirements
- R1: A start request is taken only while `busy_o` is low, and `busy_o` is high in the cycle after the request. A request made while busy has no effect on the running operation: its sector and its unlock flag are ignored.
- R2: Every operation issues exactly 256 byte loads, one per byte index 0 to 255 in ascending order. Each load goes to address {sector, index}, with the sector in the upper 10 bits and the index in the low 8 bits. Its data is the buffer word returned the cycle after `buf_req_o` with `buf_idx_o` set to that index.
- R3: When the unlock flag is high at the accepted start, three loads go out before the sector bytes. They are 0xAA to address 0x05555, then 0x55 to 0x02AAA, then 0xA0 to 0x05555. The upper address bits of these loads are zero.
- R4: Each write-enable low pulse lasts exactly WE_LOW_CYC cycles, and write-enable stays high at least WE_HIGH_CYC cycles between pulses. The address is valid for at least SETUP_CYC cycles before write-enable falls, and it does not change while write-enable is low.
- R5: The time from a write-enable rise to the next fall during an operation stays below GAP_LIMIT_CYC cycles.
- R6: Output-enable is high in every cycle in which both write-enable and chip-enable are low.
- R7: The data bus drive enable is high only while write-enable is low, and the driven value does not change during a pulse.
- R8: After the last load the sequencer reads the last loaded address with chip-enable and output-enable low, repeating the read until the read-back bit 7 equals bit 7 of the last written byte. It then raises `done_o`, drops `busy_o`, and holds `done_o` until the next accepted start.
- R9: If polling has not matched within TIMEOUT_CYC cycles of its first read, `err_o` rises and `busy_o` drops. This happens no sooner than TIMEOUT_CYC cycles and no later than TIMEOUT_CYC + POLL_ACC_CYC + POLL_GAP_CYC + 1 cycles after that first read. A later start runs normally.
- R10: In reset, write-enable, chip-enable and output-enable are high, the drive enable is low, and `busy_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| sector_i | input | 10 | Sector number for the request |
| unlock_i | input | 1 | Send the unlock prefix first |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last operation completed |
| err_o | output | 1 | Last operation timed out while polling |
| buf_req_o | output | 1 | Buffer read request |
| buf_idx_o | output | 8 | Byte index of the buffer read |
| buf_rdata_i | input | 8 | Buffer data, valid the cycle after the request |
| mem_addr_o | output | 18 | Memory address |
| mem_dq_o | output | 8 | Memory write data |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_dq_msb_i | input | 1 | Bit 7 of the memory read data |

## Verification
The bench targets the places where a sequencer of this kind tends to slip.

- **Polling and timeout.** The memory model keeps returning the complemented bit 7 for a chosen time. A sequencer that trusted a fixed wait, or compared the wrong polarity, would raise done too early or never. A model that never completes checks the timeout window exactly, so a limit that is off by a poll period is caught.
- **Extreme sector and both polarities.** The top sector (last address 0x3FFFF) is used, with last-byte data of either bit-7 polarity. This exposes a truncated address concatenation or an inverted comparison.
- **Unlock prefix.** An unlocked run checks the prefix order and the zero upper address bits. A slip here would leave the memory refusing the write.
- **Start while busy.** A start pulse in the middle of a run, carrying a different sector, must leave every address untouched. A sequencer that re-sampled its inputs would jump sectors halfway through.

// File: rtl/secprog_pkg.sv
package secprog_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_FETCH,
    PH_LATCH,
    PH_SETUP,
    PH_PULSE,
    PH_RECOV,
    PH_POLL_RD,
    PH_POLL_GAP,
    PH_DONE,
    PH_ERR
  } phase_e;

  localparam int UNLOCK_LEN = 3;

  // address of unlock write number step (15 significant bits)
  function automatic logic [14:0] unlock_addr(input logic [1:0] step);
    return (step == 2'd1) ? 15'h2AAA : 15'h5555;
  endfunction

  // data of unlock write number step
  function automatic logic [7:0] unlock_data(input logic [1:0] step);
    case (step)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/sp_cycle_timer.sv
module sp_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sp_poll_watch.sv
module sp_poll_watch #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic expired_o
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign expired_o = (cnt_q >= LAST);
  assign cnt_en    = active_i && !expired_o;

  always_comb begin
    cnt_d = cnt_q;
    if (!active_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sp_bus_drive.sv
module sp_bus_drive
  import secprog_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              we_n_o
);

  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d;

  // strobes decoded from the next phase, then registered: glitch free
  always_comb begin
    ce_n_d  = !(phase_i inside {PH_SETUP, PH_PULSE, PH_RECOV, PH_POLL_RD});
    we_n_d  = (phase_i != PH_PULSE);
    oe_n_d  = (phase_i != PH_POLL_RD);
    dq_oe_d = (phase_i == PH_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
      ce_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
    end else begin
      addr_o  <= addr_i;
      dq_o    <= data_i;
      dq_oe_o <= dq_oe_d;
      ce_n_o  <= ce_n_d;
      oe_n_o  <= oe_n_d;
      we_n_o  <= we_n_d;
    end
  end

endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq
  import secprog_pkg::*;
#(
  parameter int SECT_W        = 10,
  parameter int IDX_W         = 8,
  parameter int DATA_W        = 8,
  parameter int SETUP_CYC     = 3,
  parameter int WE_LOW_CYC    = 5,
  parameter int WE_HIGH_CYC   = 6,
  parameter int POLL_ACC_CYC  = 4,
  parameter int POLL_GAP_CYC  = 3,
  parameter int TIMEOUT_CYC   = 600000,
  parameter int GAP_LIMIT_CYC = 7500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [SECT_W-1:0]        sector_i,
  input  logic                     unlock_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o,
  output logic                     buf_req_o,
  output logic [IDX_W-1:0]         buf_idx_o,
  input  logic [DATA_W-1:0]        buf_rdata_i,
  output logic [SECT_W+IDX_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]        mem_dq_o,
  output logic                     mem_dq_oe_o,
  output logic                     mem_ce_n_o,
  output logic                     mem_oe_n_o,
  output logic                     mem_we_n_o,
  input  logic                     mem_dq_msb_i
);

  localparam int ADDR_W   = SECT_W + IDX_W;
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TMR_W    = $clog2(SETUP_CYC + WE_LOW_CYC + WE_HIGH_CYC +
                                   POLL_ACC_CYC + POLL_GAP_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = '1;
  localparam logic [1:0]       LAST_STEP = 2'(UNLOCK_LEN - 1);
  localparam int LOAD_GAP = WE_HIGH_CYC + SETUP_CYC + 2;

  // a data-load gap that reaches the limit is a parameter error
  if (LOAD_GAP >= GAP_LIMIT_CYC) begin : g_gap_guard
    $error("load gap of %0d cycles reaches limit %0d", LOAD_GAP, GAP_LIMIT_CYC);
  end

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  phase_e              phase_q, phase_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [1:0]          pstep_q, pstep_d;
  logic                prefix_q, prefix_d;
  logic [SECT_W-1:0]   sector_q, sector_d;
  logic [ADDR_W-1:0]   waddr_q, waddr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic                tmr_load, tmr_zero;
  logic [TMR_W-1:0]    tmr_val;
  logic                poll_active, poll_expired;
  logic                accept;

  assign accept = start_i && (phase_q inside {PH_IDLE, PH_DONE, PH_ERR});

  always_comb begin
    phase_d   = phase_q;
    idx_d     = idx_q;
    pstep_d   = pstep_q;
    prefix_d  = prefix_q;
    sector_d  = sector_q;
    waddr_d   = waddr_q;
    wdata_d   = wdata_q;
    buf_req_o = 1'b0;
    case (phase_q)
      PH_IDLE, PH_DONE, PH_ERR: begin
        if (accept) begin
          sector_d = sector_i;
          idx_d    = '0;
          pstep_d  = '0;
          prefix_d = unlock_i;
          if (unlock_i) begin
            waddr_d = ADDR_W'(unlock_addr(2'd0));
            wdata_d = DATA_W'(unlock_data(2'd0));
            phase_d = PH_SETUP;
          end else begin
            phase_d = PH_FETCH;
          end
        end
      end
      PH_FETCH: begin
        buf_req_o = 1'b1;
        phase_d   = PH_LATCH;
      end
      PH_LATCH: begin
        wdata_d = buf_rdata_i;
        waddr_d = {sector_q, idx_q};
        phase_d = PH_SETUP;
      end
      PH_SETUP: if (tmr_zero) phase_d = PH_PULSE;
      PH_PULSE: if (tmr_zero) phase_d = PH_RECOV;
      PH_RECOV: begin
        if (tmr_zero) begin
          if (prefix_q) begin
            if (pstep_q == LAST_STEP) begin
              prefix_d = 1'b0;
              phase_d  = PH_FETCH;
            end else begin
              pstep_d = pstep_q + 2'd1;
              waddr_d = ADDR_W'(unlock_addr(pstep_q + 2'd1));
              wdata_d = DATA_W'(unlock_data(pstep_q + 2'd1));
              phase_d = PH_SETUP;
            end
          end else if (idx_q == LAST_IDX) begin
            phase_d = PH_POLL_RD;
          end else begin
            idx_d   = idx_q + 1'b1;
            phase_d = PH_FETCH;
          end
        end
      end
      PH_POLL_RD: begin
        if (tmr_zero) begin
          if (mem_dq_msb_i == wdata_q[POLL_BIT]) begin
            phase_d = PH_DONE;
          end else if (poll_expired) begin
            phase_d = PH_ERR;
          end else begin
            phase_d = PH_POLL_GAP;
          end
        end
      end
      PH_POLL_GAP: if (tmr_zero) phase_d = PH_POLL_RD;
      default: phase_d = PH_IDLE;
    endcase
  end

  // phase durations, loaded on every phase change
  assign tmr_load = (phase_d != phase_q);
  always_comb begin
    case (phase_d)
      PH_SETUP:    tmr_val = TMR_W'(SETUP_CYC - 1);
      PH_PULSE:    tmr_val = TMR_W'(WE_LOW_CYC - 1);
      PH_RECOV:    tmr_val = TMR_W'(WE_HIGH_CYC - 1);
      PH_POLL_RD:  tmr_val = TMR_W'(POLL_ACC_CYC - 1);
      PH_POLL_GAP: tmr_val = TMR_W'(POLL_GAP_CYC - 1);
      default:     tmr_val = '0;
    endcase
  end

  sp_cycle_timer #(.W(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign poll_active = (phase_q inside {PH_POLL_RD, PH_POLL_GAP});

  sp_poll_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active_i  (poll_active),
    .expired_o (poll_expired)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      pstep_q  <= '0;
      prefix_q <= 1'b0;
      sector_q <= '0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      pstep_q  <= pstep_d;
      prefix_q <= prefix_d;
      sector_q <= sector_d;
      waddr_q  <= waddr_d;
      wdata_q  <= wdata_d;
    end
  end

  sp_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .phase_i (phase_d),
    .addr_i  (waddr_d),
    .data_i  (wdata_d),
    .addr_o  (mem_addr_o),
    .dq_o    (mem_dq_o),
    .dq_oe_o (mem_dq_oe_o),
    .ce_n_o  (mem_ce_n_o),
    .oe_n_o  (mem_oe_n_o),
    .we_n_o  (mem_we_n_o)
  );

  assign buf_idx_o = idx_q;
  assign busy_o    = !(phase_q inside {PH_IDLE, PH_DONE, PH_ERR});
  assign done_o    = (phase_q == PH_DONE);
  assign err_o     = (phase_q == PH_ERR);

endmodule

// File: rtl/sp_seq_checker.sv
module sp_seq_checker #(
  parameter int ADDR_W        = 18,
  parameter int WE_LOW_CYC    = 5,
  parameter int GAP_LIMIT_CYC = 7500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              we_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr
);

  localparam int LW = $clog2(WE_LOW_CYC + 2);
  localparam int HW = $clog2(GAP_LIMIT_CYC + 1);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      if (we_n)               low_cnt <= '0;
      else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
      if (!busy || !we_n)     hi_cnt <= '0;
      else if (hi_cnt != '1)  hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R6
  oe_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !ce_n) |-> oe_n);

  // R7
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  // R4
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(addr));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (low_cnt == LW'(WE_LOW_CYC)));

  // R5
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (hi_cnt < HW'(GAP_LIMIT_CYC)));

  // R1
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

endmodule

bind sector_prog_seq sp_seq_checker #(
  .ADDR_W        (ADDR_W),
  .WE_LOW_CYC    (WE_LOW_CYC),
  .GAP_LIMIT_CYC (GAP_LIMIT_CYC)
) u_sp_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .start (start_i),
  .busy  (busy_o),
  .done  (done_o),
  .err   (err_o),
  .we_n  (mem_we_n_o),
  .ce_n  (mem_ce_n_o),
  .oe_n  (mem_oe_n_o),
  .dq_oe (mem_dq_oe_o),
  .addr  (mem_addr_o)
);

// File: tb/sector_prog_seq_bench.sv
module sector_prog_seq_bench;

  localparam int SETUP   = 2;
  localparam int WLOW    = 3;
  localparam int WHIGH   = 3;
  localparam int PACC    = 2;
  localparam int PGAP    = 2;
  localparam int TMO     = 3000;
  localparam int GAPLIM  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  sector = '0;
  logic        unlock = 1'b0;
  logic        busy, done, err, buf_req;
  logic [7:0]  buf_idx;
  logic [7:0]  buf_rdata = '0;
  logic [17:0] addr;
  logic [7:0]  dq;
  logic        dq_oe, ce_n, oe_n, we_n;
  logic        dq_msb;

  always #10 clk = ~clk;

  sector_prog_seq #(
    .SETUP_CYC(SETUP), .WE_LOW_CYC(WLOW), .WE_HIGH_CYC(WHIGH),
    .POLL_ACC_CYC(PACC), .POLL_GAP_CYC(PGAP), .TIMEOUT_CYC(TMO),
    .GAP_LIMIT_CYC(GAPLIM)
  ) u_sector_prog_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sector_i(sector),
    .unlock_i(unlock), .busy_o(busy), .done_o(done), .err_o(err),
    .buf_req_o(buf_req), .buf_idx_o(buf_idx), .buf_rdata_i(buf_rdata),
    .mem_addr_o(addr), .mem_dq_o(dq), .mem_dq_oe_o(dq_oe),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_dq_msb_i(dq_msb)
  );

  int n_chk = 0;
  int n_bad = 0;

  // buffer pattern
  logic [7:0] seed = '0;
  function automatic logic [7:0] pat(input logic [7:0] s, input logic [7:0] i);
    return (i * 8'd13) ^ s;
  endfunction

  always @(posedge clk) if (buf_req) buf_rdata <= pat(seed, buf_idx);

  // memory model: bit 7 complemented while programming is pending
  logic       poll_hold = 1'b1;
  logic [7:0] exp_last = '0;
  assign dq_msb = poll_hold ? ~exp_last[7] : exp_last[7];

  // bus monitor, sampled at the falling clock edge
  logic [17:0] log_a [0:511];
  logic [7:0]  log_d [0:511];
  int nload = 0, npoll = 0, cyc = 0, t_poll = 0;
  int low_run = 0, hi_run = 0, addr_run = 0, max_gap = 0;
  int v_oe = 0, v_dq = 0, v_addr = 0, v_low = 0, v_hi = 0, v_setup = 0, v_paddr = 0;
  logic        prev_we_n = 1'b1;
  logic [17:0] prev_addr = '0, cur_a = '0, exp_poll_addr = '0;
  logic [7:0]  cur_d = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!we_n && !ce_n && !oe_n) v_oe++;
      if (dq_oe && we_n) v_dq++;
      if (!we_n) begin
        if (prev_we_n) begin
          if (addr_run < SETUP) v_setup++;
          if (nload > 0 && hi_run < WHIGH) v_hi++;
          if (nload > 0 && hi_run > max_gap) max_gap = hi_run;
          cur_a = addr;
          cur_d = dq;
          low_run = 0;
        end else if (addr != cur_a) v_addr++;
        if (!dq_oe || dq != cur_d) v_dq++;
        low_run++;
      end else begin
        if (!prev_we_n) begin
          if (nload < 512) begin
            log_a[nload] = cur_a;
            log_d[nload] = cur_d;
          end
          if (low_run != WLOW) v_low++;
          nload++;
          hi_run = 0;
        end
        hi_run++;
      end
      if (!oe_n) begin
        npoll++;
        if (npoll == 1) t_poll = cyc;
        if (ce_n || addr != exp_poll_addr) v_paddr++;
      end
      addr_run = (addr == prev_addr) ? addr_run + 1 : 1;
      prev_addr = addr;
      prev_we_n = we_n;
    end
  end

  task automatic check(input string req, input string what, input longint act,
                       input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_loads(input int n);
    int g = 0;
    while (nload < n && g < 20000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic kick(input logic [9:0] sec, input logic u, input logic [7:0] s);
    @(negedge clk);
    seed = s;
    exp_last = pat(s, 8'hFF);
    exp_poll_addr = {sec, 8'hFF};
    poll_hold = 1'b1;
    nload = 0;
    npoll = 0;
    sector = sec;
    unlock = u;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1", "busy after start", busy, 1);
    check("R8", "done cleared by start", done, 0);
  endtask

  task automatic finish_poll(input int hold_cyc);
    int g = 0;
    repeat (hold_cyc) @(negedge clk);
    check("R8", "still busy before match", busy, 1);
    check("R8", "no done before match", done, 0);
    check("R8", "poll reads seen", (npoll > 0) ? 1 : 0, 1);
    poll_hold = 1'b0;
    while (!done && g < 50) begin
      @(negedge clk);
      g++;
    end
    check("R8", "done soon after match", (g <= PACC + PGAP + 2) ? 1 : 0, 1);
    check("R8", "busy low at done", busy, 0);
    check("R8", "poll address and ce", v_paddr, 0);
  endtask

  task automatic check_sector(input logic [9:0] sec, input int base, input logic [7:0] s);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      if (log_a[base+i] != {sec, 8'(i)} || log_d[base+i] != pat(s, 8'(i))) bad++;
    end
    check("R2", "sector load mismatches", bad, 0);
  endtask

  task automatic check_timing();
    check("R4", "pulse length errors", v_low, 0);
    check("R4", "short high between pulses", v_hi, 0);
    check("R4", "setup before fall", v_setup, 0);
    check("R4", "addr moved in pulse", v_addr, 0);
    check("R5", "max load gap below limit", (max_gap < GAPLIM) ? 1 : 0, 1);
    check("R6", "oe low during write", v_oe, 0);
    check("R7", "drive outside pulse", v_dq, 0);
  endtask

  task automatic t_reset();
    check("R10", "we_n in reset", we_n, 1);
    check("R10", "ce_n in reset", ce_n, 1);
    check("R10", "oe_n in reset", oe_n, 1);
    check("R10", "dq_oe in reset", dq_oe, 0);
    check("R10", "busy/done/err in reset", {busy, done, err}, 0);
  endtask

  task automatic t_plain(input logic [9:0] sec, input logic [7:0] s);
    kick(sec, 1'b0, s);
    wait_loads(256);
    finish_poll(40);
    check("R2", "load count", nload, 256);
    check_sector(sec, 0, s);
    check_timing();
  endtask

  task automatic t_unlock();
    kick(10'h0A5, 1'b1, 8'h3C);
    wait_loads(259);
    finish_poll(10);
    check("R3", "load count with prefix", nload, 259);
    check("R3", "prefix 1", {log_a[0], log_d[0]}, {18'h05555, 8'hAA});
    check("R3", "prefix 2", {log_a[1], log_d[1]}, {18'h02AAA, 8'h55});
    check("R3", "prefix 3", {log_a[2], log_d[2]}, {18'h05555, 8'hA0});
    check_sector(10'h0A5, 3, 8'h3C);
    check_timing();
  endtask

  task automatic t_busy_ignore();
    kick(10'h123, 1'b0, 8'h11);
    wait_loads(100);
    @(negedge clk);
    sector = 10'h2F0;
    unlock = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_loads(256);
    finish_poll(20);
    check("R1", "loads with start while busy", nload, 256);
    check_sector(10'h123, 0, 8'h11);
  endtask

  task automatic t_timeout();
    int g = 0;
    int dt;
    kick(10'h077, 1'b0, 8'h00);
    wait_loads(256);
    while (!err && g < TMO + 500) begin
      @(negedge clk);
      g++;
    end
    dt = cyc - t_poll;
    check("R9", "err raised", err, 1);
    check("R9", "busy low after timeout", busy, 0);
    check("R9", "done low after timeout", done, 0);
    check("R9", "timeout not early", (dt >= TMO) ? 1 : 0, 1);
    check("R9", "timeout not late", (dt <= TMO + PACC + PGAP + 1) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain(10'h155, 8'h00);
    t_plain(10'h3FF, 8'h80);
    t_unlock();
    t_busy_ignore();
    t_timeout();
    t_plain(10'h001, 8'h5A);
    check("R9", "err cleared by restart", err, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule